// File: doc/BRIEF.md
# Load/Store Alignment Unit

This unit connects a 32-bit integer register path to a big-endian, single-port, word-wide memory data port. It takes one memory operation at a time (an opcode, a byte address, a register index and up to two register source values), works out which byte lanes are involved, and runs the memory transfers through a request/ready handshake. Load results are extended and returned on a register writeback port. Stores are placed in the correct lanes under byte enables.

Two register-pair forms move eight bytes between an even/odd register pair and two consecutive memory words. Two indivisible forms are also supported. The first reads a byte and then sets it to all ones. The second exchanges a register with a memory word. Both hold a lock output across their read and write, so that an external arbiter can keep other requesters out.

Operations that break natural alignment, or that name an odd register for a pair transfer, do not touch memory or registers. Instead they end with a trap pulse.

Top module: `lsau_top`

## Requirements
- R1: Opcode 0 (signed byte load) and opcode 1 (unsigned byte load) return the byte at offset `addr[1:0]`, where offset 0 is bits 31:24 of the memory word and offset 3 is bits 7:0. Opcode 0 sign-extends the byte to 32 bits and opcode 1 zero-extends it.
- R2: Opcode 2 (signed half load) and opcode 3 (unsigned half load) return bits 31:16 when `addr[1]` is 0 and bits 15:0 when it is 1. Opcode 2 sign-extends the value and opcode 3 zero-extends it.
- R3: Opcode 4 (word load) writes the addressed memory word unchanged to register `in_rd`.
- R4: Opcode 5 (pair load) reads the word at the 8-byte-aligned address into register `in_rd`, then reads the word at address+4 into register `in_rd`+1. The writebacks occur in that order.
- R5: Opcode 6 (byte store) copies bits 7:0 of `in_src_a` into every byte lane and enables only lane `mem_be[3-addr[1:0]]`. Opcode 7 (half store) copies bits 15:0 into both halves and enables `mem_be[3:2]` for `addr[1]`=0 or `mem_be[1:0]` for `addr[1]`=1. Bit `mem_be[i]` covers `mem_wdata[8i+7:8i]`.
- R6: Opcode 8 (word store) writes `in_src_a` with all four enables set. Opcode 9 (pair store) writes `in_src_a` at the aligned address and then `in_src_b` at address+4.
- R7: A half operation with `addr[0]`=1, a word operation (opcodes 4, 8, 11) with `addr[1:0]`≠0, or a pair operation with `addr[2:0]`≠0 raises `trap_align` together with `done`. It issues no memory request and no writeback. Byte operations never raise `trap_align`.
- R8: A pair operation (opcode 5 or 9) with an odd `in_rd` raises `trap_illegal` together with `done`, with no memory request and no writeback. This check takes priority over the alignment check, so the two traps never appear together.
- R9: Opcode 10 (test-and-set byte) returns the old byte, zero-extended and laned as in R1, to `in_rd`. It then writes 0xFF into that byte only, leaving the other bytes of the word unchanged.
- R10: Opcode 11 (exchange) returns the old memory word to `in_rd` and writes `in_src_a` into the same word.
- R11: For opcodes 10 and 11, `mem_lock` is high on both the read transfer and the write transfer, and it stays high between them. Every other opcode performs all of its transfers with `mem_lock` low.
- R12: While `mem_ready` is low, a pending request keeps its address, direction, data and enables unchanged. `in_ready` is low while a request is outstanding, and `done` pulses for one cycle after the final transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Unit idle, request accepted this cycle |
| in_op | input | 4 | Opcode (0 to 11, see requirements) |
| in_addr | input | 32 | Byte address |
| in_rd | input | 5 | Destination or source register index |
| in_src_a | input | 32 | Value of register `in_rd` |
| in_src_b | input | 32 | Value of register `in_rd`+1 (pair store) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Indivisible sequence in progress |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables, bit i covers bits 8i+7:8i |
| mem_ready | input | 1 | Transfer completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| wb_valid | output | 1 | Register writeback strobe |
| wb_rd | output | 5 | Writeback register index |
| wb_data | output | 32 | Writeback value |
| done | output | 1 | Operation finished (one-cycle pulse) |
| trap_align | output | 1 | Misalignment trap, with `done` |
| trap_illegal | output | 1 | Odd register in a pair operation, with `done` |

## Verification
The hardest case to reach from the ports is an indivisible sequence whose read or write is held off by memory wait states. In that case the lock must survive the stall, and the write must land only in the lanes that were read. The stimulus sweeps every opcode against all eight byte offsets of a double word and both register parities. The bench memory model cycles its latency between zero and two wait states, so each transfer phase is stalled in some runs. Runs that combine an odd register with a misaligned pair address exercise the priority between the two traps.

// File: rtl/lsau_pkg.sv
package lsau_pkg;

  typedef enum logic [3:0] {
    OP_LD_BYTE_S = 4'd0,
    OP_LD_BYTE_U = 4'd1,
    OP_LD_HALF_S = 4'd2,
    OP_LD_HALF_U = 4'd3,
    OP_LD_WORD   = 4'd4,
    OP_LD_PAIR   = 4'd5,
    OP_ST_BYTE   = 4'd6,
    OP_ST_HALF   = 4'd7,
    OP_ST_WORD   = 4'd8,
    OP_ST_PAIR   = 4'd9,
    OP_TAS_BYTE  = 4'd10,
    OP_XCHG_WORD = 4'd11
  } lsu_op_e;

  typedef enum logic [1:0] {SZ_B, SZ_H, SZ_W, SZ_D} size_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_WR0, ST_WR1
  } phase_e;

  function automatic size_e op_size(lsu_op_e op);
    case (op)
      OP_LD_BYTE_S, OP_LD_BYTE_U, OP_ST_BYTE, OP_TAS_BYTE: return SZ_B;
      OP_LD_HALF_S, OP_LD_HALF_U, OP_ST_HALF:              return SZ_H;
      OP_LD_PAIR, OP_ST_PAIR:                              return SZ_D;
      default:                                             return SZ_W;
    endcase
  endfunction

  function automatic logic op_signed(lsu_op_e op);
    return (op == OP_LD_BYTE_S) || (op == OP_LD_HALF_S);
  endfunction

  function automatic logic op_atomic(lsu_op_e op);
    return (op == OP_TAS_BYTE) || (op == OP_XCHG_WORD);
  endfunction

  function automatic logic op_reads_first(lsu_op_e op);
    return (op <= OP_LD_PAIR) || op_atomic(op);
  endfunction

endpackage

// File: rtl/lsau_align_check.sv
module lsau_align_check
  import lsau_pkg::*;
(
  input  lsu_op_e    op,
  input  logic [2:0] addr_lo,
  input  logic       rd_lsb,
  output logic       misaligned,
  output logic       illegal
);
  size_e sz;

  always_comb begin
    sz      = op_size(op);
    illegal = (sz == SZ_D) && rd_lsb;
    case (sz)
      SZ_B:    misaligned = 1'b0;
      SZ_H:    misaligned = addr_lo[0];
      SZ_W:    misaligned = |addr_lo[1:0];
      default: misaligned = |addr_lo;
    endcase
  end
endmodule

// File: rtl/lsau_load_lane.sv
module lsau_load_lane
  import lsau_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]            word,
  input  logic [$clog2(XLEN/8)-1:0]  ofs,
  input  size_e                      size,
  input  logic                       sgn,
  output logic [XLEN-1:0]            result
);
  localparam int BYTES  = XLEN / 8;
  localparam int HALVES = BYTES / 2;
  localparam int OW     = $clog2(BYTES);

  logic [7:0]  blane [BYTES];
  logic [15:0] hlane [HALVES];
  logic [7:0]  bsel;
  logic [15:0] hsel;

  // lane 0 is the most significant byte of the word
  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    assign blane[k] = word[(BYTES-1-k)*8 +: 8];
  end
  for (genvar k = 0; k < HALVES; k++) begin : g_half
    assign hlane[k] = word[(HALVES-1-k)*16 +: 16];
  end

  always_comb begin
    bsel = blane[ofs];
    hsel = hlane[ofs[OW-1:1]];
    case (size)
      SZ_B:    result = sgn ? {{(XLEN-8){bsel[7]}}, bsel}
                            : {{(XLEN-8){1'b0}}, bsel};
      SZ_H:    result = sgn ? {{(XLEN-16){hsel[15]}}, hsel}
                            : {{(XLEN-16){1'b0}}, hsel};
      default: result = word;
    endcase
  end
endmodule

// File: rtl/lsau_store_lane.sv
module lsau_store_lane
  import lsau_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]            data,
  input  logic [$clog2(XLEN/8)-1:0]  ofs,
  input  size_e                      size,
  output logic [XLEN-1:0]            wdata,
  output logic [XLEN/8-1:0]          be
);
  localparam int BYTES = XLEN / 8;
  localparam int OW    = $clog2(BYTES);

  for (genvar i = 0; i < BYTES; i++) begin : g_be
    localparam int K = BYTES - 1 - i;
    assign be[i] = (size == SZ_B) ? (ofs == OW'(K)) :
                   (size == SZ_H) ? (ofs[OW-1:1] == (OW-1)'(K / 2)) :
                   1'b1;
  end

  always_comb begin
    case (size)
      SZ_B:    wdata = {BYTES{data[7:0]}};
      SZ_H:    wdata = {(BYTES/2){data[15:0]}};
      default: wdata = data;
    endcase
  end
endmodule

// File: rtl/lsau_top.sv
module lsau_top
  import lsau_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 32,
  parameter int REG_AW = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [3:0]          in_op,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [REG_AW-1:0]   in_rd,
  input  logic [XLEN-1:0]     in_src_a,
  input  logic [XLEN-1:0]     in_src_b,
  output logic                mem_req,
  output logic                mem_we,
  output logic                mem_lock,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [XLEN-1:0]     mem_wdata,
  output logic [XLEN/8-1:0]   mem_be,
  input  logic                mem_ready,
  input  logic [XLEN-1:0]     mem_rdata,
  output logic                wb_valid,
  output logic [REG_AW-1:0]   wb_rd,
  output logic [XLEN-1:0]     wb_data,
  output logic                done,
  output logic                trap_align,
  output logic                trap_illegal
);
  localparam int BYTES = XLEN / 8;
  localparam int OW    = $clog2(BYTES);

  phase_e             state;
  lsu_op_e            op_q;
  logic [OW-1:0]      off_q;
  logic [REG_AW-1:0]  rd_q;
  logic [XLEN-1:0]    src_a_q, src_b_q;

  lsu_op_e            op_in;
  logic               in_mis, in_ill;
  logic [XLEN-1:0]    ld_val;
  logic [XLEN-1:0]    sl_data, sl_wdata;
  logic [OW-1:0]      sl_ofs;
  size_e              sl_size;
  logic [BYTES-1:0]   sl_be;
  logic [ADDR_W-1:0]  in_base;

  assign op_in    = lsu_op_e'(in_op);
  assign in_ready = (state == ST_IDLE);
  assign in_base  = {in_addr[ADDR_W-1:OW], {OW{1'b0}}};

  lsau_align_check u_align (
    .op         (op_in),
    .addr_lo    (in_addr[2:0]),
    .rd_lsb     (in_rd[0]),
    .misaligned (in_mis),
    .illegal    (in_ill)
  );

  lsau_load_lane #(.XLEN(XLEN)) u_load (
    .word   (mem_rdata),
    .ofs    (off_q),
    .size   (op_size(op_q)),
    .sgn    (op_signed(op_q)),
    .result (ld_val)
  );

  // shared store laner: new requests in idle, set-byte enables afterwards
  always_comb begin
    if (state == ST_IDLE) begin
      sl_data = in_src_a;
      sl_ofs  = in_addr[OW-1:0];
      sl_size = op_size(op_in);
    end else begin
      sl_data = '1;
      sl_ofs  = off_q;
      sl_size = SZ_B;
    end
  end

  lsau_store_lane #(.XLEN(XLEN)) u_store (
    .data  (sl_data),
    .ofs   (sl_ofs),
    .size  (sl_size),
    .wdata (sl_wdata),
    .be    (sl_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      op_q         <= OP_LD_WORD;
      off_q        <= '0;
      rd_q         <= '0;
      src_a_q      <= '0;
      src_b_q      <= '0;
      mem_req      <= 1'b0;
      mem_we       <= 1'b0;
      mem_lock     <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      mem_be       <= '0;
      wb_valid     <= 1'b0;
      wb_rd        <= '0;
      wb_data      <= '0;
      done         <= 1'b0;
      trap_align   <= 1'b0;
      trap_illegal <= 1'b0;
    end else begin
      wb_valid     <= 1'b0;
      done         <= 1'b0;
      trap_align   <= 1'b0;
      trap_illegal <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            op_q    <= op_in;
            off_q   <= in_addr[OW-1:0];
            rd_q    <= in_rd;
            src_a_q <= in_src_a;
            src_b_q <= in_src_b;
            if (in_ill) begin
              trap_illegal <= 1'b1;
              done         <= 1'b1;
            end else if (in_mis) begin
              trap_align <= 1'b1;
              done       <= 1'b1;
            end else if (op_reads_first(op_in)) begin
              state    <= ST_RD0;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_lock <= op_atomic(op_in);
              mem_addr <= in_base;
              mem_be   <= '1;
            end else begin
              state     <= ST_WR0;
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_lock  <= 1'b0;
              mem_addr  <= in_base;
              mem_wdata <= sl_wdata;
              mem_be    <= sl_be;
            end
          end
        end
        ST_RD0: begin
          if (mem_ready) begin
            wb_valid <= 1'b1;
            wb_rd    <= rd_q;
            wb_data  <= ld_val;
            case (op_q)
              OP_LD_PAIR: begin
                state    <= ST_RD1;
                mem_addr <= mem_addr + ADDR_W'(BYTES);
              end
              OP_TAS_BYTE: begin
                state     <= ST_WR0;
                mem_we    <= 1'b1;
                mem_wdata <= sl_wdata;
                mem_be    <= sl_be;
              end
              OP_XCHG_WORD: begin
                state     <= ST_WR0;
                mem_we    <= 1'b1;
                mem_wdata <= src_a_q;
                mem_be    <= '1;
              end
              default: begin
                state   <= ST_IDLE;
                mem_req <= 1'b0;
                done    <= 1'b1;
              end
            endcase
          end
        end
        ST_RD1: begin
          if (mem_ready) begin
            wb_valid <= 1'b1;
            wb_rd    <= {rd_q[REG_AW-1:1], 1'b1};
            wb_data  <= mem_rdata;
            state    <= ST_IDLE;
            mem_req  <= 1'b0;
            done     <= 1'b1;
          end
        end
        ST_WR0: begin
          if (mem_ready) begin
            if (op_q == OP_ST_PAIR) begin
              state     <= ST_WR1;
              mem_addr  <= mem_addr + ADDR_W'(BYTES);
              mem_wdata <= src_b_q;
              mem_be    <= '1;
            end else begin
              state    <= ST_IDLE;
              mem_req  <= 1'b0;
              mem_we   <= 1'b0;
              mem_lock <= 1'b0;
              done     <= 1'b1;
            end
          end
        end
        ST_WR1: begin
          if (mem_ready) begin
            state   <= ST_IDLE;
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            done    <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsau_chk.sv
module lsau_chk
  import lsau_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 32,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        in_op,
  input logic [ADDR_W-1:0] in_addr,
  input logic [REG_AW-1:0] in_rd,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_lock,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [XLEN-1:0]   mem_wdata,
  input logic [XLEN/8-1:0] mem_be,
  input logic              mem_ready,
  input logic              wb_valid,
  input logic              done,
  input logic              trap_align,
  input logic              trap_illegal
);
  logic pair_op, half_op, word_op, bad_addr, odd_pair;

  assign pair_op  = (in_op == 4'd5) || (in_op == 4'd9);
  assign half_op  = (in_op == 4'd2) || (in_op == 4'd3) || (in_op == 4'd7);
  assign word_op  = (in_op == 4'd4) || (in_op == 4'd8) || (in_op == 4'd11);
  assign odd_pair = pair_op && in_rd[0];
  assign bad_addr = (half_op && in_addr[0]) || (word_op && (in_addr[1:0] != 2'b00))
                 || (pair_op && (in_addr[2:0] != 3'b000));

  // R7
  align_suppress_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && bad_addr && !odd_pair) |=> (!mem_req && trap_align && done));

  // R8
  illegal_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && odd_pair) |=> (!mem_req && trap_illegal && !trap_align));

  // R8
  trap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (trap_align || trap_illegal) |-> (done && !wb_valid));

  // R11
  atomic_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready && !mem_we && mem_lock) |=> (mem_req && mem_we && mem_lock));

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata) && $stable(mem_be) && $stable(mem_lock)));

  // R12
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !in_ready);

  // R5
  be_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                             || $countones(mem_be) == XLEN/8));
endmodule

bind lsau_top lsau_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .in_addr(in_addr), .in_rd(in_rd), .mem_req(mem_req), .mem_we(mem_we),
  .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
  .mem_ready(mem_ready), .wb_valid(wb_valid), .done(done), .trap_align(trap_align),
  .trap_illegal(trap_illegal)
);

// File: tb/lsau_top_test.sv
module lsau_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_addr = '0;
  logic [4:0]  in_rd = '0;
  logic [31:0] in_src_a = '0, in_src_b = '0;
  logic        mem_req, mem_we, mem_lock;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        wb_valid;
  logic [4:0]  wb_rd;
  logic [31:0] wb_data;
  logic        done, trap_align, trap_illegal;

  always #10 clk = ~clk;

  lsau_top uut (.*);

  int n_tests = 0, n_fail = 0;
  logic [31:0] mem [16];
  int lat = 0, wcnt = 0;
  bit pend = 0;
  logic p_we, p_lock;
  logic [3:0] p_idx, p_be;
  logic [31:0] p_wd;
  int xfer_n, lock_n, wb_n;
  logic [4:0]  wbr [2];
  logic [31:0] wbd [2];
  bit done_seen, got_ta, got_ti;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model and output monitor, all at the falling edge
  always @(negedge clk) begin
    if (pend) begin
      if (p_we)
        for (int i = 0; i < 4; i++)
          if (p_be[i]) mem[p_idx][8*i +: 8] = p_wd[8*i +: 8];
      xfer_n++;
      if (p_lock) lock_n++;
      pend = 0;
    end
    if (wb_valid) begin
      if (wb_n < 2) begin wbr[wb_n] = wb_rd; wbd[wb_n] = wb_data; end
      wb_n++;
    end
    if (done) begin done_seen = 1; got_ta = trap_align; got_ti = trap_illegal; end
    if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ready = 1'b1;
        mem_rdata = mem[mem_addr[5:2]];
        pend = 1; p_we = mem_we; p_lock = mem_lock; p_idx = mem_addr[5:2];
        p_be = mem_be; p_wd = mem_wdata; wcnt = 0;
      end else begin
        mem_ready = 1'b0;
        wcnt++;
      end
    end else mem_ready = 1'b0;
  end

  task automatic run_op(int op, logic [2:0] off, logic [4:0] rd, logic [31:0] a,
                        logic [31:0] b, logic [31:0] w0, logic [31:0] w1);
    logic [31:0] addr, ow, e0, e1, ew, v;
    logic [7:0] byt;
    logic [15:0] hw;
    bit ill, mis, pair, half, word, atom;
    int exp_wb;
    string r;
    @(posedge clk); #2;
    mem[8] = w0; mem[9] = w1;
    xfer_n = 0; lock_n = 0; wb_n = 0; done_seen = 0; got_ta = 0; got_ti = 0;
    addr = 32'h20 + 32'(off);
    in_op = 4'(op); in_addr = addr; in_rd = rd; in_src_a = a; in_src_b = b;
    in_valid = 1'b1;
    @(posedge clk); #2;
    in_valid = 1'b0;
    for (int t = 0; t < 60 && !done_seen; t++) @(posedge clk);
    #2;
    pair = (op == 5 || op == 9);
    half = (op == 2 || op == 3 || op == 7);
    word = (op == 4 || op == 8 || op == 11);
    atom = (op == 10 || op == 11);
    ill  = pair && rd[0];
    mis  = !ill && ((half && off[0]) || (word && off[1:0] != 0) || (pair && off != 0));
    ow   = off[2] ? w1 : w0;
    byt  = 8'(ow >> (8 * (3 - int'(off[1:0]))));
    hw   = off[1] ? ow[15:0] : ow[31:16];
    e0 = w0; e1 = w1; exp_wb = 0; v = '0; ew = ow;
    if (ill) r = "R8"; else if (mis) r = "R7";
    else case (op)
      0, 1: r = "R1"; 2, 3: r = "R2"; 4: r = "R3"; 5: r = "R4";
      6, 7: r = "R5"; 8, 9: r = "R6"; 10: r = "R9"; default: r = "R10";
    endcase
    chk(r, "done", 32'(done_seen), 32'd1);
    chk(r, "trap_illegal", 32'(got_ti), 32'(ill));
    chk(r, "trap_align", 32'(got_ta), 32'(mis));
    if (!ill && !mis) begin
      case (op)
        0: begin exp_wb = 1; v = {{24{byt[7]}}, byt}; end
        1, 10: begin exp_wb = 1; v = {24'd0, byt}; end
        2: begin exp_wb = 1; v = {{16{hw[15]}}, hw}; end
        3: begin exp_wb = 1; v = {16'd0, hw}; end
        4, 11: begin exp_wb = 1; v = ow; end
        5: exp_wb = 2;
        default: exp_wb = 0;
      endcase
      case (op)
        6: for (int i = 0; i < 4; i++) if (3 - i == int'(off[1:0])) ew[8*i +: 8] = a[7:0];
        7: if (off[1]) ew[15:0] = a[15:0]; else ew[31:16] = a[15:0];
        8, 11: ew = a;
        10: for (int i = 0; i < 4; i++) if (3 - i == int'(off[1:0])) ew[8*i +: 8] = 8'hFF;
        default: ;
      endcase
      if (off[2]) e1 = ew; else e0 = ew;
      if (op == 9) begin e0 = a; e1 = b; end
    end
    chk(r, "writeback count", 32'(wb_n), 32'(exp_wb));
    if (exp_wb == 1 && wb_n >= 1) begin
      chk(r, "wb reg", 32'(wbr[0]), 32'(rd));
      chk(r, "wb data", wbd[0], v);
    end
    if (exp_wb == 2 && wb_n >= 2) begin
      chk("R4", "first reg", 32'(wbr[0]), 32'(rd));
      chk("R4", "first data", wbd[0], w0);
      chk("R4", "second reg", 32'(wbr[1]), 32'(rd | 5'd1));
      chk("R4", "second data", wbd[1], w1);
    end
    chk(r, "mem word 0", mem[8], e0);
    chk(r, "mem word 1", mem[9], e1);
    chk("R11", "locked transfers", 32'(lock_n), (atom && !mis) ? 32'd2 : 32'd0);
    chk("R12", "transfer count", 32'(xfer_n),
        (ill || mis) ? 32'd0 : ((pair || atom) ? 32'd2 : 32'd1));
  endtask

  initial begin
    int k = 0;
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk("R12", "reset in_ready", 32'(in_ready), 32'd1);
    chk("R12", "reset mem_req", 32'(mem_req), 32'd0);
    chk("R12", "reset done", 32'(done), 32'd0);
    chk("R11", "reset lock", 32'(mem_lock), 32'd0);
    for (int op = 0; op < 12; op++)
      for (int off = 0; off < 8; off++)
        for (int rp = 0; rp < 2; rp++) begin
          lat = k % 3;
          run_op(op, 3'(off), 5'(6 + rp),
                 32'h1234_5687 ^ (32'(k) << 9) ^ 32'(k * 131),
                 32'hC0DE_0F1A + 32'(k * 7),
                 32'h9A3C_5E71 + 32'(k) * 32'h0107_0305,
                 32'hF00D_8421 ^ (32'(k) * 32'h0011_2233));
          k++;
        end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule